// File: doc/BRIEF.md
# Oversampling Serial Receiver with Phase Realignment

This block receives asynchronous serial characters (one start bit, eight data bits, one stop bit) on a single input line. It samples the line only on cycles where a sample enable, running at sixteen times the bit rate, is high. Each bit period is split into sixteen sample phases, numbered 1 to 16. The value of each bit is the majority of the samples at phases 8, 9 and 10. Data bits are shifted in least significant bit first.

A character starts on a falling edge of the line while idle. That edge defines phase 1 of the start bit. If the start bit then votes high, it is taken as a false start and the receiver goes back to idle. Within a character, the phase count is realigned to any 1-to-0 transition that follows a bit which voted 1. The new edge becomes phase 1 of the next bit, so a moderate bit-rate mismatch on either side is tolerated.

When the stop bit has been voted, the assembled byte is copied into a read-only holding register and a full flag is raised. The full flag is cleared by a read strobe. An interrupt output follows the full flag when the interrupt enable is high. The stop bit value is not checked.

Top module: `osrx_top`

## Requirements
- R1: After reset, rx_data is 0x00, rx_full is 0 and rx_irq is 0.
- R2: While idle, a 1 sample followed by a 0 sample on consecutive enabled ticks starts a character, and that tick is phase 1. If the start bit's phase 8/9/10 majority is 1, the receiver returns to idle and neither rx_data nor rx_full changes. A later valid character is still received correctly.
- R3: Each bit value is the majority of the samples at phases 8, 9 and 10. A single opposite sample at phase 9 does not change the received bit.
- R4: The 8 data bits following the start bit are placed with the first one at rx_data bit 0 and the last one at bit 7. rx_data changes only when a character completes, which is at the phase 10 vote of the stop bit.
- R5: A 1-to-0 transition that follows a bit voted 1 reloads the phase count so that the transition is phase 1 of the next bit. This applies whether the transition arrives early (phases 11 to 16 of the current bit) or late (phases 2 to 7 of the new bit). As a result, characters with a bit period of 14 or 18 enable ticks are received correctly when they contain such transitions.
- R6: Character completion sets rx_full, and a completion in the same cycle as rd_strobe wins. rd_strobe without a completion clears rx_full on the next clock. A character that completes while rx_full is set replaces rx_data, and rx_full stays 1.
- R7: rx_irq is 1 exactly when rx_full is 1 and irq_en is 1.
- R8: On cycles where rt_tick is 0, the line is not sampled and the receiver state does not advance. A character sent with ticks on alternate cycles is received correctly. Line activity while rt_tick is held low starts no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_tick | input | 1 | Sample enable at 16 times the bit rate |
| rxd_in | input | 1 | Serial receive line, idles high |
| irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Read of the holding register, clears the full flag |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Holding register holds an unread byte |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest situation to reach from the ports is mid-character realignment. Both the early case (the edge lands in phases 11 to 16 and moves the bit index forward) and the late case (the edge lands in phases 2 to 7 of the next bit) only occur when the sender's bit period differs from sixteen ticks. The stimulus sends alternating bit patterns with bit periods of 18 and 14 ticks. In the 18-tick case, sampling without realignment would drift into the neighbouring bit by the sixth data bit, so a receiver that does not realign fails. Each 1-to-0 edge then lands in the late window for slow characters and in the early window for fast ones.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  // two-of-three vote
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/osrx_phase.sv
module osrx_phase #(
  parameter int OVS = 16,
  parameter int SMP = 8,
  parameter int PW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic          load,
  input  logic          run,
  output logic [PW-1:0] ph_now,
  output logic          fall,
  output logic          vote_ev,
  output logic          vote
);
  import osrx_pkg::*;

  localparam logic [PW-1:0] PH_LAST = PW'(OVS);
  localparam logic [PW-1:0] PH_A    = PW'(SMP);
  localparam logic [PW-1:0] PH_B    = PW'(SMP + 1);
  localparam logic [PW-1:0] PH_C    = PW'(SMP + 2);

  function automatic logic [PW-1:0] step_ph(input logic [PW-1:0] p);
    return (p == PH_LAST) ? PW'(1) : p + PW'(1);
  endfunction

  logic [PW-1:0] phase;
  logic          last_s;
  logic          s_a;
  logic          s_b;

  assign ph_now  = step_ph(phase);
  assign fall    = tick & last_s & ~rxd;
  assign vote_ev = tick & run & (ph_now == PH_C);
  assign vote    = vote3(s_a, s_b, rxd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_LAST;
      last_s <= 1'b1;
      s_a    <= 1'b1;
      s_b    <= 1'b1;
    end else if (tick) begin
      last_s <= rxd;
      if (load)     phase <= PW'(1);
      else if (run) phase <= ph_now;
      if (run && ph_now == PH_A) s_a <= rxd;
      if (run && ph_now == PH_B) s_b <= rxd;
    end
  end

endmodule

// File: rtl/osrx_ctrl.sv
module osrx_ctrl #(
  parameter int OVS = 16,
  parameter int SMP = 8,
  parameter int DW  = 8,
  parameter int PW  = 5,
  parameter int IW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fall,
  input  logic [PW-1:0] ph_now,
  input  logic          vote_ev,
  input  logic          vote,
  output logic          load,
  output logic          busy,
  output logic          start_ev,
  output logic          realign,
  output logic          char_done,
  output logic [DW-1:0] shreg
);
  import osrx_pkg::*;

  localparam logic [IW-1:0] IDX_STOP  = IW'(DW + 1);
  localparam logic [IW-1:0] IDX_LASTD = IW'(DW);
  localparam logic [PW-1:0] EARLY_LO  = PW'(SMP + 3);
  localparam logic [PW-1:0] LATE_HI   = PW'(SMP - 1);
  localparam logic [PW-1:0] PH_LAST   = PW'(OVS);

  rx_state_e     state;
  logic [IW-1:0] idx;
  logic          maj_last;
  logic          synced;
  logic          early;
  logic          late;
  logic          false_start;

  assign busy        = (state == RX_BUSY);
  assign start_ev    = tick & ~busy & fall;
  assign early       = tick & busy & maj_last & fall & (ph_now >= EARLY_LO)
                       & (idx != '0) & (idx <= IDX_LASTD);
  assign late        = tick & busy & maj_last & fall & (ph_now >= PW'(2))
                       & (ph_now <= LATE_HI) & ~synced & (idx >= IW'(2));
  assign realign     = early | late;
  assign load        = start_ev | realign;
  assign char_done   = vote_ev & (idx == IDX_STOP);
  assign false_start = vote_ev & (idx == '0) & vote;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      idx      <= '0;
      maj_last <= 1'b0;
      synced   <= 1'b0;
      shreg    <= '0;
    end else if (tick) begin
      if (!busy) begin
        if (start_ev) begin
          state    <= RX_BUSY;
          idx      <= '0;
          maj_last <= 1'b0;
          synced   <= 1'b0;
        end
      end else if (vote_ev) begin
        maj_last <= vote;
        if (idx != '0 && idx <= IDX_LASTD) shreg <= {vote, shreg[DW-1:1]};
        if (false_start || char_done) state <= RX_IDLE;
      end else if (early) begin
        idx    <= idx + IW'(1);
        synced <= 1'b1;
      end else if (late) begin
        synced <= 1'b1;
      end else if (ph_now == PH_LAST) begin
        idx    <= idx + IW'(1);
        synced <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/osrx_buf.sv
module osrx_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] din,
  input  logic          rd,
  output logic [DW-1:0] data,
  output logic          full
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      if (wr) data <= din;
      if (wr)      full <= 1'b1;
      else if (rd) full <= 1'b0;
    end
  end

endmodule

// File: rtl/osrx_top.sv
module osrx_top #(
  parameter int OVS = 16,
  parameter int SMP = 8,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rt_tick,
  input  logic          rxd_in,
  input  logic          irq_en,
  input  logic          rd_strobe,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          rx_irq
);

  localparam int PW = $clog2(OVS) + 1;
  localparam int IW = $clog2(DW + 2);

  logic [PW-1:0] ph_now;
  logic          fall;
  logic          vote_ev;
  logic          vote;
  logic          load;
  logic          busy;
  logic          start_ev;
  logic          realign;
  logic          char_done;
  logic [DW-1:0] shreg;

  osrx_phase #(.OVS(OVS), .SMP(SMP), .PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(rt_tick), .rxd(rxd_in),
    .load(load), .run(busy), .ph_now(ph_now), .fall(fall),
    .vote_ev(vote_ev), .vote(vote)
  );

  osrx_ctrl #(.OVS(OVS), .SMP(SMP), .DW(DW), .PW(PW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(rt_tick), .fall(fall),
    .ph_now(ph_now), .vote_ev(vote_ev), .vote(vote), .load(load),
    .busy(busy), .start_ev(start_ev), .realign(realign),
    .char_done(char_done), .shreg(shreg)
  );

  osrx_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(char_done), .din(shreg),
    .rd(rd_strobe), .data(rx_data), .full(rx_full)
  );

  assign rx_irq = rx_full & irq_en;

endmodule

// File: rtl/osrx_chk.sv
module osrx_chk #(
  parameter int DW = 8,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rt_tick,
  input logic          rd_strobe,
  input logic          irq_en,
  input logic [DW-1:0] rx_data,
  input logic          rx_full,
  input logic          rx_irq,
  input logic          char_done,
  input logic          realign,
  input logic          start_ev,
  input logic          busy,
  input logic [PW-1:0] ph_now
);

  // R6
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_full);

  // R6
  full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !char_done) |=> !rx_full);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !char_done |=> $stable(rx_data));

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !rx_irq);

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);

  // R8
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_tick |=> $stable(ph_now));

  // R5
  realign_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> (busy && rt_tick));

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (busy && ph_now == PW'(2)));

endmodule

bind osrx_top osrx_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .rd_strobe(rd_strobe),
  .irq_en(irq_en), .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
  .char_done(char_done), .realign(realign), .start_ev(start_ev),
  .busy(busy), .ph_now(ph_now)
);

// File: tb/sim_osrx_top.sv
module sim_osrx_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rt_tick = 1'b1;
  logic       rxd_in = 1'b1;
  logic       irq_en = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full;
  logic       rx_irq;
  int         tick_mode = 0;  // 0 always on, 1 alternate, 2 off
  int         n_chk = 0;
  int         n_err = 0;
  int         cyc = 0;

  always #5 clk = ~clk;

  osrx_top u0 (
    .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .rxd_in(rxd_in),
    .irq_en(irq_en), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .rx_full(rx_full), .rx_irq(rx_irq)
  );

  always @(negedge clk) begin
    if (tick_mode == 1)      rt_tick <= ~rt_tick;
    else if (tick_mode == 2) rt_tick <= 1'b0;
    else                     rt_tick <= 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // gbit: data bit (0..7) that gets one inverted sample at phase 9, -1 none
  task automatic send_frame(input logic [7:0] b, input int cpb, input int gbit);
    for (int k = 0; k < 10; k++) begin
      logic v;
      v = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
      for (int j = 0; j < cpb; j++) begin
        @(negedge clk);
        rxd_in = (k >= 1 && k <= 8 && gbit == k - 1 && j == 8) ? ~v : v;
      end
    end
    rxd_in = 1'b1;
    idle(4);
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 data", rx_data, 8'h00);
    check("R1 full", rx_full, 0);
    check("R1 irq", rx_irq, 0);
  endtask

  task automatic t_basic();
    irq_en = 1'b0;
    send_frame(8'hA5, 16, -1);
    check("R4 data A5", rx_data, 8'hA5);
    check("R6 full set", rx_full, 1);
    check("R7 irq masked", rx_irq, 0);
    irq_en = 1'b1;
    idle(1);
    check("R7 irq on", rx_irq, 1);
    do_read();
    check("R6 full cleared", rx_full, 0);
    check("R7 irq off after read", rx_irq, 0);
    check("R4 data kept after read", rx_data, 8'hA5);
    irq_en = 1'b0;
  endtask

  task automatic t_overwrite();
    send_frame(8'h3C, 16, -1);
    check("R4 data 3C", rx_data, 8'h3C);
    send_frame(8'hC3, 16, -1);
    check("R6 overwrite data", rx_data, 8'hC3);
    check("R6 full stays", rx_full, 1);
    do_read();
    check("R6 full cleared again", rx_full, 0);
  endtask

  task automatic t_false_start();
    @(negedge clk); rxd_in = 1'b0;
    idle(4);
    rxd_in = 1'b1;
    idle(30);
    check("R2 false start no full", rx_full, 0);
    check("R2 false start data kept", rx_data, 8'hC3);
    send_frame(8'h81, 16, -1);
    check("R2 frame after false start", rx_data, 8'h81);
    do_read();
  endtask

  task automatic t_glitch();
    send_frame(8'hF0, 16, 4);
    check("R3 low glitch in 1 bit", rx_data, 8'hF0);
    do_read();
    send_frame(8'hF0, 16, 1);
    check("R3 high glitch in 0 bit", rx_data, 8'hF0);
    do_read();
  endtask

  task automatic t_rate();
    send_frame(8'h55, 18, -1);
    check("R5 slow 55 late realign", rx_data, 8'h55);
    do_read();
    send_frame(8'hAA, 18, -1);
    check("R5 slow AA late realign", rx_data, 8'hAA);
    do_read();
    send_frame(8'h55, 14, -1);
    check("R5 fast 55 early realign", rx_data, 8'h55);
    do_read();
  endtask

  task automatic t_tick_gate();
    tick_mode = 1;
    idle(4);
    send_frame(8'h6E, 32, -1);
    idle(8);
    check("R8 alternate tick frame", rx_data, 8'h6E);
    do_read();
    tick_mode = 2;
    idle(2);
    rxd_in = 1'b0;
    idle(40);
    rxd_in = 1'b1;
    idle(4);
    tick_mode = 0;
    idle(200);
    check("R8 no start while tick low", rx_full, 0);
    check("R8 data kept while tick low", rx_data, 8'h6E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_basic();
    t_overwrite();
    t_false_start();
    t_glitch();
    t_rate();
    t_tick_gate();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule